// File: doc/BRIEF.md
# Branch Target Cache Predictor

This block predicts change-of-flow instructions at the fetch stage. It is read in the same cycle as the instruction cache, using the current fetch address. Each of its direct-mapped entries holds an address tag, a branch target and a 2-bit saturating history counter. If a valid entry matches and its counter leans taken, the block steers the next fetch address to the stored target. In every other case it hands back the sequential address.

When a branch reaches the execute stage, the pipeline reports it on the resolve port. The report carries the branch's address, its real direction and target, and the prediction that travelled with it. The block compares the outcome with that prediction. On a mismatch it raises a flush and supplies the corrected fetch address in the same cycle, and that address overrides any prediction. At the following clock edge it trains the matching entry, or it allocates a fresh entry for a taken branch that missed.

Top module: `btc_predictor`

## Requirements
- R1: After reset every entry is invalid, so each lookup reports `pred_hit`=0 and `pred_taken`=0, and `next_fetch_pc` equals `fetch_pc`+4.
- R2: A lookup that hits an entry whose counter is 2 or 3 drives `pred_taken`=1. In that same cycle, `next_fetch_pc` equals the stored target.
- R3: A lookup that misses, or that hits an entry whose counter is 0 or 1, drives `pred_taken`=0 and `next_fetch_pc`=`fetch_pc`+4.
- R4: A resolve report is a mispredict in two cases: the actual direction differs from `rslv_pred_taken`, or the branch is taken with `rslv_target` different from `rslv_pred_target`. A mispredict drives `flush`=1 in the same cycle. A report that matches its prediction keeps `flush`=0.
- R5: During a flush, `next_fetch_pc` and `flush_pc` carry the corrected address, which overrides any lookup result. The corrected address is `rslv_target` for a taken branch and `rslv_pc`+4 for a not-taken one.
- R6: A resolve that hits an entry steps its counter: up for taken, saturating at 3, and down for not-taken, saturating at 0. A taken resolve also replaces the stored target with `rslv_target`.
- R7: A taken resolve that misses allocates an entry with counter 2 (weakly taken). The entry is visible to lookups from the next cycle.
- R8: A not-taken resolve that misses leaves the array unchanged.
- R9: The entry index is address bits [8:1] and the tag is bits [31:9]; bit 0 takes no part. Two addresses with the same index but different tags never hit each other's entry, and a taken allocation replaces whatever entry held that index.
- R10: When a resolve writes the index being looked up in the same cycle, the lookup returns the entry's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | 32 | Current fetch address looked up |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Lookup predicts taken |
| pred_target | output | 32 | Stored target of the matched entry |
| next_fetch_pc | output | 32 | Address for the next fetch |
| rslv_valid | input | 1 | Resolve report present this cycle |
| rslv_pc | input | 32 | Address of the resolved branch |
| rslv_taken | input | 1 | Actual direction |
| rslv_target | input | 32 | Actual target |
| rslv_pred_taken | input | 1 | Direction that was predicted |
| rslv_pred_target | input | 32 | Target that was predicted |
| flush | output | 1 | Mispredict: discard the fetch and execute pipelines |
| flush_pc | output | 32 | Corrected restart address |

## Verification
A wrong counter or a lost valid bit shows up on the very next lookup of that address. It appears as a `pred_taken` or `pred_hit` value that disagrees with the count of resolves applied to the address since reset. A wrong tag or index split shows up as aliasing between addresses 0x200 apart. A write that lands a cycle early shows up as a hit during the colliding cycle. A wrong mispredict decision shows up at once on `flush` and `next_fetch_pc` in the resolve cycle itself. The directed sequences walk one counter through both saturation points and compare every step at the ports.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_TAKEN = 2'd2;

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/btc_array.sv
module btc_array
  import btc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = ADDR_W - IDX_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_target,
  output ctr_t              rd_ctr,
  input  logic [IDX_W-1:0]  rs_idx,
  output logic              rs_valid,
  output logic [TAG_W-1:0]  rs_tag,
  output logic [ADDR_W-1:0] rs_target,
  output ctr_t              rs_ctr,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_target,
  input  ctr_t              wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_vec;
  logic [TAG_W-1:0]  tag_vec [DEPTH];
  logic [ADDR_W-1:0] tgt_vec [DEPTH];
  ctr_t              ctr_vec [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              sel;
    logic              valid_r;
    logic [TAG_W-1:0]  tag_r;
    logic [ADDR_W-1:0] tgt_r;
    ctr_t              ctr_r;

    always_comb sel = wr_en && (rs_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid_r <= 1'b0;
      else if (sel) valid_r <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_r <= wr_tag;
        tgt_r <= wr_target;
        ctr_r <= wr_ctr;
      end
    end

    assign valid_vec[i] = valid_r;
    assign tag_vec[i]   = tag_r;
    assign tgt_vec[i]   = tgt_r;
    assign ctr_vec[i]   = ctr_r;
  end

  always_comb begin
    rd_valid  = valid_vec[rd_idx];
    rd_tag    = tag_vec[rd_idx];
    rd_target = tgt_vec[rd_idx];
    rd_ctr    = ctr_vec[rd_idx];
    rs_valid  = valid_vec[rs_idx];
    rs_tag    = tag_vec[rs_idx];
    rs_target = tgt_vec[rs_idx];
    rs_ctr    = ctr_vec[rs_idx];
  end
endmodule

// File: rtl/btc_lookup.sv
module btc_lookup
  import btc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 8,
  parameter int TAG_W       = ADDR_W - IDX_W - 1,
  parameter int FETCH_BYTES = 4
) (
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [ADDR_W-1:0] rd_target,
  input  ctr_t              rd_ctr,
  output logic              hit,
  output logic              taken,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] guess_pc
);
  always_comb begin
    rd_idx   = fetch_pc[IDX_W:1];
    hit      = rd_valid && (rd_tag == fetch_pc[ADDR_W-1:IDX_W+1]);
    taken    = hit && ctr_says_taken(rd_ctr);
    target   = rd_target;
    guess_pc = taken ? rd_target : fetch_pc + ADDR_W'(FETCH_BYTES);
  end
endmodule

// File: rtl/btc_resolve.sv
module btc_resolve
  import btc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 8,
  parameter int TAG_W       = ADDR_W - IDX_W - 1,
  parameter int FETCH_BYTES = 4
) (
  input  logic              rslv_valid,
  input  logic [ADDR_W-1:0] rslv_pc,
  input  logic              rslv_taken,
  input  logic [ADDR_W-1:0] rslv_target,
  input  logic              rslv_pred_taken,
  input  logic [ADDR_W-1:0] rslv_pred_target,
  output logic [IDX_W-1:0]  rs_idx,
  input  logic              rs_valid,
  input  logic [TAG_W-1:0]  rs_tag,
  input  logic [ADDR_W-1:0] rs_target,
  input  ctr_t              rs_ctr,
  output logic              rs_hit,
  output logic              wr_en,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [ADDR_W-1:0] wr_target,
  output ctr_t              wr_ctr,
  output logic              mispredict,
  output logic [ADDR_W-1:0] fix_pc
);
  always_comb begin
    rs_idx    = rslv_pc[IDX_W:1];
    wr_tag    = rslv_pc[ADDR_W-1:IDX_W+1];
    rs_hit    = rs_valid && (rs_tag == wr_tag);
    wr_en     = rslv_valid && (rs_hit || rslv_taken);
    wr_target = rslv_taken ? rslv_target : rs_target;
    wr_ctr    = rs_hit ? ctr_step(rs_ctr, rslv_taken) : CTR_WEAK_TAKEN;

    mispredict = rslv_valid &&
                 ((rslv_taken != rslv_pred_taken) ||
                  (rslv_taken && (rslv_target != rslv_pred_target)));
    fix_pc     = rslv_taken ? rslv_target : rslv_pc + ADDR_W'(FETCH_BYTES);
  end
endmodule

// File: rtl/btc_predictor.sv
module btc_predictor
  import btc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 8,
  parameter int FETCH_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  output logic [ADDR_W-1:0] next_fetch_pc,
  input  logic              rslv_valid,
  input  logic [ADDR_W-1:0] rslv_pc,
  input  logic              rslv_taken,
  input  logic [ADDR_W-1:0] rslv_target,
  input  logic              rslv_pred_taken,
  input  logic [ADDR_W-1:0] rslv_pred_target,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_pc
);
  localparam int TAG_W = ADDR_W - IDX_W - 1;

  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic [IDX_W-1:0]  rd_idx, rs_idx;
  logic              rd_valid, rs_valid, rs_hit, wr_en, mispredict;
  logic [TAG_W-1:0]  rd_tag, rs_tag, wr_tag;
  logic [ADDR_W-1:0] rd_target, rs_target, wr_target, guess_pc, fix_pc;
  ctr_t              rd_ctr, rs_ctr, wr_ctr;

  btc_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_array (
    .clk(clk), .rst_n(rst_q_n),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_target(rd_target), .rd_ctr(rd_ctr),
    .rs_idx(rs_idx), .rs_valid(rs_valid), .rs_tag(rs_tag),
    .rs_target(rs_target), .rs_ctr(rs_ctr),
    .wr_en(wr_en), .wr_tag(wr_tag), .wr_target(wr_target), .wr_ctr(wr_ctr)
  );

  btc_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
               .FETCH_BYTES(FETCH_BYTES)) i_lookup (
    .fetch_pc(fetch_pc), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_tag(rd_tag), .rd_target(rd_target), .rd_ctr(rd_ctr),
    .hit(pred_hit), .taken(pred_taken), .target(pred_target),
    .guess_pc(guess_pc)
  );

  btc_resolve #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
                .FETCH_BYTES(FETCH_BYTES)) i_resolve (
    .rslv_valid(rslv_valid), .rslv_pc(rslv_pc), .rslv_taken(rslv_taken),
    .rslv_target(rslv_target), .rslv_pred_taken(rslv_pred_taken),
    .rslv_pred_target(rslv_pred_target),
    .rs_idx(rs_idx), .rs_valid(rs_valid), .rs_tag(rs_tag),
    .rs_target(rs_target), .rs_ctr(rs_ctr), .rs_hit(rs_hit),
    .wr_en(wr_en), .wr_tag(wr_tag), .wr_target(wr_target), .wr_ctr(wr_ctr),
    .mispredict(mispredict), .fix_pc(fix_pc)
  );

  always_comb begin
    flush         = mispredict;
    flush_pc      = fix_pc;
    next_fetch_pc = mispredict ? fix_pc : guess_pc;
  end
endmodule

// File: rtl/btc_checker.sv
module btc_checker #(
  parameter int ADDR_W      = 32,
  parameter int FETCH_BYTES = 4
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_target,
  input logic [ADDR_W-1:0] next_fetch_pc,
  input logic              rslv_valid,
  input logic [ADDR_W-1:0] rslv_pc,
  input logic              rslv_taken,
  input logic [ADDR_W-1:0] rslv_target,
  input logic              flush,
  input logic              rs_hit
);
  a_r2_taken_implies_hit: assert property (@(posedge clk) disable iff (!rst_q_n)
    pred_taken |-> pred_hit);

  a_r3_sequential: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!flush && !pred_taken) |-> (next_fetch_pc == fetch_pc + ADDR_W'(FETCH_BYTES)));

  a_r4_flush_needs_resolve: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rslv_valid |-> !flush);

  a_r7_alloc_visible: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rslv_valid && rslv_taken) |=>
      ((fetch_pc != $past(rslv_pc)) || (pred_hit && pred_target == $past(rslv_target))));

  a_r8_no_alloc_not_taken: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rslv_valid && !rslv_taken && !rs_hit) |=>
      ((fetch_pc != $past(rslv_pc)) || !pred_hit));

  a_r10_old_on_collide: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rslv_valid && !rs_hit && fetch_pc == rslv_pc) |-> !pred_hit);
endmodule

bind btc_predictor btc_checker #(.ADDR_W(ADDR_W), .FETCH_BYTES(FETCH_BYTES)) i_chk (
  .clk(clk), .rst_q_n(rst_q_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
  .pred_taken(pred_taken), .pred_target(pred_target),
  .next_fetch_pc(next_fetch_pc), .rslv_valid(rslv_valid), .rslv_pc(rslv_pc),
  .rslv_taken(rslv_taken), .rslv_target(rslv_target), .flush(flush),
  .rs_hit(rs_hit)
);

// File: tb/test_btc_predictor.sv
module test_btc_predictor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        pred_hit, pred_taken, flush;
  logic [31:0] pred_target, next_fetch_pc, flush_pc;
  logic        rslv_valid, rslv_taken, rslv_pred_taken;
  logic [31:0] rslv_pc, rslv_target, rslv_pred_target;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  btc_predictor i_btc_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .next_fetch_pc(next_fetch_pc), .rslv_valid(rslv_valid), .rslv_pc(rslv_pc),
    .rslv_taken(rslv_taken), .rslv_target(rslv_target),
    .rslv_pred_taken(rslv_pred_taken), .rslv_pred_target(rslv_pred_target),
    .flush(flush), .flush_pc(flush_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Lookup only: checks hit, taken and next address.
  task automatic look(input string req, input logic [31:0] pc,
                      input logic hit, input logic tk, input logic [31:0] nxt);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    chk({req, " hit"},   32'(pred_hit),   32'(hit));
    chk({req, " taken"}, 32'(pred_taken), 32'(tk));
    chk({req, " next"},  next_fetch_pc,   nxt);
  endtask

  // Resolve report: checks flush and corrected address, then lets it write.
  task automatic resolve(input string req, input logic [31:0] pc, input logic tk,
                         input logic [31:0] tgt, input logic ptk,
                         input logic [31:0] ptgt, input logic exp_flush,
                         input logic [31:0] exp_next);
    @(negedge clk);
    fetch_pc         = 32'h0000_8000;
    rslv_valid       = 1'b1;
    rslv_pc          = pc;
    rslv_taken       = tk;
    rslv_target      = tgt;
    rslv_pred_taken  = ptk;
    rslv_pred_target = ptgt;
    #1;
    chk({req, " flush"}, 32'(flush), 32'(exp_flush));
    if (exp_flush) begin
      chk({req, " next"},     next_fetch_pc, exp_next);
      chk({req, " flush_pc"}, flush_pc,      exp_next);
    end
    @(negedge clk);
    rslv_valid = 1'b0;
  endtask

  task automatic t_reset;
    look("R1 empty", 32'h0000_1000, 1'b0, 1'b0, 32'h0000_1004);
    look("R1 empty2", 32'h0000_0100, 1'b0, 1'b0, 32'h0000_0104);
  endtask

  task automatic t_alloc;
    resolve("R4 alloc mispredict", 32'h100, 1'b1, 32'h2000, 1'b0, 32'h0, 1'b1, 32'h2000);
    look("R7 R2 new entry", 32'h100, 1'b1, 1'b1, 32'h2000);
  endtask

  task automatic t_counter;
    resolve("R5 nt flush", 32'h100, 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, 32'h104);
    look("R6 ctr1 R3", 32'h100, 1'b1, 1'b0, 32'h104);
    resolve("R4 correct nt", 32'h100, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
    look("R6 ctr0", 32'h100, 1'b1, 1'b0, 32'h104);
    resolve("R4 t vs nt", 32'h100, 1'b1, 32'h2000, 1'b0, 32'h0, 1'b1, 32'h2000);
    look("R6 ctr1 after sat0", 32'h100, 1'b1, 1'b0, 32'h104);
    resolve("R4 t again", 32'h100, 1'b1, 32'h2000, 1'b0, 32'h0, 1'b1, 32'h2000);
    look("R6 ctr2", 32'h100, 1'b1, 1'b1, 32'h2000);
    resolve("R4 correct t", 32'h100, 1'b1, 32'h2000, 1'b1, 32'h2000, 1'b0, 32'h0);
    resolve("R4 correct t2", 32'h100, 1'b1, 32'h2000, 1'b1, 32'h2000, 1'b0, 32'h0);
    resolve("R5 nt from sat3", 32'h100, 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, 32'h104);
    look("R6 ctr2 after sat3", 32'h100, 1'b1, 1'b1, 32'h2000);
  endtask

  task automatic t_target;
    resolve("R4 wrong target", 32'h100, 1'b1, 32'h3000, 1'b1, 32'h2000, 1'b1, 32'h3000);
    look("R6 target updated", 32'h100, 1'b1, 1'b1, 32'h3000);
  endtask

  task automatic t_nt_miss;
    resolve("R8 nt miss", 32'h400, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
    look("R8 still empty", 32'h400, 1'b0, 1'b0, 32'h404);
  endtask

  task automatic t_alias;
    look("R9 alias miss", 32'h300, 1'b0, 1'b0, 32'h304);
    look("R9 bit0 ignored", 32'h101, 1'b1, 1'b1, 32'h3000);
    resolve("R9 alias alloc", 32'h300, 1'b1, 32'h5000, 1'b0, 32'h0, 1'b1, 32'h5000);
    look("R9 new owner", 32'h300, 1'b1, 1'b1, 32'h5000);
    look("R9 old evicted", 32'h100, 1'b0, 1'b0, 32'h104);
  endtask

  task automatic t_collide;
    @(negedge clk);
    fetch_pc         = 32'h500;
    rslv_valid       = 1'b1;
    rslv_pc          = 32'h500;
    rslv_taken       = 1'b1;
    rslv_target      = 32'h6000;
    rslv_pred_taken  = 1'b0;
    rslv_pred_target = 32'h0;
    #1;
    chk("R10 old contents", 32'(pred_hit), 32'd0);
    chk("R5 flush overrides", next_fetch_pc, 32'h6000);
    @(negedge clk);
    rslv_valid = 1'b0;
    #1;
    chk("R10 written after edge", 32'(pred_hit), 32'd1);
    chk("R10 next after edge", next_fetch_pc, 32'h6000);
  endtask

  initial begin
    rst_n = 1'b0; fetch_pc = 32'h0; rslv_valid = 1'b0; rslv_pc = 32'h0;
    rslv_taken = 1'b0; rslv_target = 32'h0; rslv_pred_taken = 1'b0;
    rslv_pred_target = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_alloc();
    t_counter();
    t_target();
    t_nt_miss();
    t_alias();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule